// File: doc/BRIEF.md
# Memory-to-Memory DMA Channel

This block is a single DMA channel that copies data between two regions of memory without processor involvement. Software loads a source address, a destination address, a unit count and a control halfword through a small register write port. Setting the enable bit in the control halfword arms the channel. On that 0-to-1 transition the channel takes working copies of the programmed addresses and count. It then moves one unit at a time over a request/ready memory master port. A unit is 16 or 32 bits, read first and then written.

After each unit the working source and destination addresses move up, move down or stay put, each according to its own 2-bit mode. When the working count runs out, the channel clears its own enable bit and may raise a one-cycle interrupt. The parameter `CHAN_ID` (0 to 3) selects how many address bits survive programming and how wide the count is, so the same RTL serves all four channels of a controller.

Top module: `mdma_channel`

## Requirements
- R1: A programmed source address keeps its low 27 bits when CHAN_ID is 0 and its low 28 bits otherwise; higher bits read as zero on the memory port.
- R2: A programmed destination address keeps its low 28 bits when CHAN_ID is 3 and its low 27 bits otherwise.
- R3: The count is 16 bits wide for CHAN_ID 3 and 14 bits wide for the other channels; a write keeps only that many low bits of reg_wr_data[15:0].
- R4: The working addresses and count load only when a control write takes the enable bit (control bit 15) from 0 to 1. Rewriting control with enable already 1, or writing address or count registers during a transfer, does not alter the transfer in progress. Later arming uses the newly programmed values.
- R5: A count of zero at arming gives the all-ones value of the count width as the number of units.
- R6: Control bit 10 selects the unit size: 1 gives 32-bit units with an address step of 4, 0 gives 16-bit units with a step of 2. A 16-bit unit writes zero in mem_wdata[31:16]. mem_wide carries the selected size on every access.
- R7: Adjustment codes are 0 increment, 1 decrement and 2 hold, for both the destination (control bits 6:5) and the source (control bits 8:7). Destination code 3 increments.
- R8: Source code 3 leaves the source address unchanged, sets src_err and keeps it set until reset, and the transfer still runs to completion.
- R9: Each unit is a read from the working source followed by a write of the same data to the working destination. A request holds its address and direction until mem_ready is seen, and the write follows the accepted read directly.
- R10: After the last unit's write is accepted, the enable bit reads 0 and the other control bits are kept. irq pulses for exactly one cycle if control bit 14 is set, and not at all otherwise.
- R11: After reset, control reads zero, no request is made and irq and src_err are low. While enable is 0 no access is issued, and every control bit written reads back unchanged.
- R12: Register select 0 writes the source, 1 the destination and 2 the count/control pair. In that pair reg_wr_be[0] writes the count from bits 15:0 and reg_wr_be[1] writes control from bits 31:16. A write of both halves arms with the count written in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 2 | Register select (0 source, 1 destination, 2 count/control) |
| reg_wr_be | input | 2 | Half enables for select 2 (bit 0 count, bit 1 control) |
| reg_wr_data | input | 32 | Register write data |
| ctrl_rd | output | 16 | Current control halfword |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_wide | output | 1 | 1 for 32-bit access, 0 for 16-bit |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ready on a read |
| mem_ready | input | 1 | Accepts the current request at the clock edge |
| irq | output | 1 | One-cycle completion interrupt |
| src_err | output | 1 | Sticky flag for an illegal source adjustment code |

## Verification
The arming write lands on one clock edge, and the first read request appears in the second cycle after that edge. Each access completes on the edge where mem_ready is high, and the next request (write after read, or the next read) is visible in the cycle after that edge. The cleared enable bit and the irq pulse both show in the single cycle that follows the edge accepting the last write.

The bench's memory model raises mem_ready at a falling edge after a programmable wait. At that same moment it compares the access against the head of the expected queue, so every comparison happens on the value that the next rising edge will take. Completion checks run only after the queue has drained, the request has dropped and enable has cleared, plus a few settling cycles, so the one-cycle irq pulse has been counted before the check reads the count.

// File: rtl/mdma_pkg.sv
package mdma_pkg;

   localparam int REG_W  = 32;
   localparam int HALF_W = 16;

   // control halfword field positions
   localparam int CTL_DADJ = 5;
   localparam int CTL_SADJ = 7;
   localparam int CTL_WIDE = 10;
   localparam int CTL_IRQ  = 14;
   localparam int CTL_EN   = 15;

   localparam logic [1:0] SEL_SRC    = 2'd0;
   localparam logic [1:0] SEL_DST    = 2'd1;
   localparam logic [1:0] SEL_CNTCTL = 2'd2;

   typedef enum logic [1:0] {
      ADJ_UP    = 2'd0,
      ADJ_DOWN  = 2'd1,
      ADJ_HOLD  = 2'd2,
      ADJ_UP_RL = 2'd3
   } adj_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_READ  = 2'd1,
      ST_WRITE = 2'd2
   } seq_e;

   function automatic int src_bits(input int id);
      return (id == 0) ? 27 : 28;
   endfunction

   function automatic int dst_bits(input int id);
      return (id == 3) ? 28 : 27;
   endfunction

   function automatic int cnt_bits(input int id);
      return (id == 3) ? 16 : 14;
   endfunction

endpackage

// File: rtl/mdma_regs.sv
module mdma_regs
   import mdma_pkg::*;
#(
   parameter int CHAN_ID = 0,
   parameter int ADDR_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [1:0]        wr_be,
   input  logic [REG_W-1:0]  wr_data,
   input  logic              done_i,
   output logic [ADDR_W-1:0] src_prog,
   output logic [ADDR_W-1:0] dst_prog,
   output logic [HALF_W-1:0] cnt_load,
   output logic [HALF_W-1:0] ctrl_q,
   output logic              reload_o
);

   localparam int SRC_W = src_bits(CHAN_ID);
   localparam int DST_W = dst_bits(CHAN_ID);
   localparam int CNT_W = cnt_bits(CHAN_ID);
   localparam logic [ADDR_W-1:0] SRC_MASK = ADDR_W'((64'd1 << SRC_W) - 64'd1);
   localparam logic [ADDR_W-1:0] DST_MASK = ADDR_W'((64'd1 << DST_W) - 64'd1);
   localparam logic [HALF_W-1:0] CNT_MASK = HALF_W'((64'd1 << CNT_W) - 64'd1);

   logic [ADDR_W-1:0] src_q, dst_q;
   logic [HALF_W-1:0] cnt_q, cnt_eff;
   logic [ADDR_W-1:0] addr_in;
   logic              wr_src, wr_dst, wr_cnt, wr_ctl;

   assign addr_in = ADDR_W'(wr_data);
   assign wr_src  = wr_en && (wr_sel == SEL_SRC);
   assign wr_dst  = wr_en && (wr_sel == SEL_DST);
   assign wr_cnt  = wr_en && (wr_sel == SEL_CNTCTL) && wr_be[0];
   assign wr_ctl  = wr_en && (wr_sel == SEL_CNTCTL) && wr_be[1];

   // a count written alongside the arming control write is the one used
   assign cnt_eff  = wr_cnt ? (wr_data[HALF_W-1:0] & CNT_MASK) : cnt_q;
   assign cnt_load = (cnt_eff == '0) ? CNT_MASK : cnt_eff;
   assign reload_o = wr_ctl && wr_data[HALF_W+CTL_EN] && !ctrl_q[CTL_EN];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         src_q  <= '0;
         dst_q  <= '0;
         cnt_q  <= '0;
         ctrl_q <= '0;
      end else begin
         if (wr_src) src_q <= addr_in & SRC_MASK;
         if (wr_dst) dst_q <= addr_in & DST_MASK;
         if (wr_cnt) cnt_q <= cnt_eff;
         if (wr_ctl) ctrl_q <= wr_data[REG_W-1:HALF_W];
         if (done_i) ctrl_q[CTL_EN] <= 1'b0;
      end
   end

   assign src_prog = src_q;
   assign dst_prog = dst_q;

endmodule

// File: rtl/mdma_addr_walk.sv
module mdma_addr_walk
   import mdma_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter bit IS_SRC = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic              step_i,
   input  logic [1:0]        mode_i,
   input  logic              wide_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic              err_o
);

   logic [ADDR_W-1:0] addr_q, addr_nxt, rl_nxt, step_sz;

   assign step_sz = wide_i ? ADDR_W'(4) : ADDR_W'(2);

   generate
      if (IS_SRC) begin : g_src
         logic err_q;
         // code 3 is not a legal source mode: hold and flag
         assign rl_nxt = addr_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               err_q <= 1'b0;
            else if (step_i && (adj_e'(mode_i) == ADJ_UP_RL))
               err_q <= 1'b1;
         end
         assign err_o = err_q;
      end else begin : g_dst
         assign rl_nxt = addr_q + step_sz;
         assign err_o  = 1'b0;
      end
   endgenerate

   always_comb begin
      case (adj_e'(mode_i))
         ADJ_UP:   addr_nxt = addr_q + step_sz;
         ADJ_DOWN: addr_nxt = addr_q - step_sz;
         ADJ_HOLD: addr_nxt = addr_q;
         default:  addr_nxt = rl_nxt;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         addr_q <= '0;
      else if (load_i)
         addr_q <= load_addr;
      else if (step_i)
         addr_q <= addr_nxt;
   end

   assign addr_o = addr_q;

endmodule

// File: rtl/mdma_unit_seq.sv
module mdma_unit_seq
   import mdma_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic              wide_i,
   input  logic              irq_en_i,
   input  logic              load_i,
   input  logic [HALF_W-1:0] load_cnt,
   input  logic [ADDR_W-1:0] src_addr,
   input  logic [ADDR_W-1:0] dst_addr,
   input  logic [REG_W-1:0]  mem_rdata,
   input  logic              mem_ready,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [REG_W-1:0]  mem_wdata,
   output logic              unit_done_o,
   output logic              last_o,
   output logic              irq_o
);

   seq_e              state_q, state_nxt;
   logic [HALF_W-1:0] cnt_q;
   logic [REG_W-1:0]  data_q;
   logic              rd_ack, unit_done, last_unit;

   assign rd_ack    = (state_q == ST_READ) && mem_ready;
   assign unit_done = (state_q == ST_WRITE) && mem_ready;
   assign last_unit = unit_done && (cnt_q == HALF_W'(1));

   always_comb begin
      state_nxt = state_q;
      case (state_q)
         ST_IDLE:  if (en_i) state_nxt = ST_READ;
         ST_READ:  if (mem_ready) state_nxt = ST_WRITE;
         ST_WRITE: if (mem_ready) state_nxt = (last_unit || !en_i) ? ST_IDLE : ST_READ;
         default:  state_nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         data_q  <= '0;
         irq_o   <= 1'b0;
      end else begin
         state_q <= state_nxt;
         irq_o   <= last_unit && irq_en_i;
         if (load_i)
            cnt_q <= load_cnt;
         else if (unit_done)
            cnt_q <= cnt_q - HALF_W'(1);
         if (rd_ack)
            data_q <= wide_i ? mem_rdata : {{(REG_W-HALF_W){1'b0}}, mem_rdata[HALF_W-1:0]};
      end
   end

   assign mem_req     = (state_q != ST_IDLE);
   assign mem_we      = (state_q == ST_WRITE);
   assign mem_addr    = (state_q == ST_WRITE) ? dst_addr : src_addr;
   assign mem_wdata   = data_q;
   assign unit_done_o = unit_done;
   assign last_o      = last_unit;

endmodule

// File: rtl/mdma_channel.sv
module mdma_channel
   import mdma_pkg::*;
#(
   parameter int CHAN_ID = 0,
   parameter int ADDR_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_en,
   input  logic [1:0]        reg_wr_sel,
   input  logic [1:0]        reg_wr_be,
   input  logic [31:0]       reg_wr_data,
   output logic [15:0]       ctrl_rd,
   output logic              mem_req,
   output logic              mem_we,
   output logic              mem_wide,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [31:0]       mem_wdata,
   input  logic [31:0]       mem_rdata,
   input  logic              mem_ready,
   output logic              irq,
   output logic              src_err
);

   localparam int N_WALK = 2;

   if (CHAN_ID < 0 || CHAN_ID > 3) begin : g_bad_id
      $error("mdma_channel: CHAN_ID must lie in 0..3");
   end
   if (ADDR_W < 28 || ADDR_W > REG_W) begin : g_bad_aw
      $error("mdma_channel: ADDR_W must lie in 28..32");
   end

   logic [ADDR_W-1:0] prog_addr [N_WALK];
   logic [ADDR_W-1:0] work_addr [N_WALK];
   logic [N_WALK-1:0] walk_err;
   logic [HALF_W-1:0] cnt_load, ctrl_q;
   logic              reload, unit_done, last_unit;

   mdma_regs #(.CHAN_ID(CHAN_ID), .ADDR_W(ADDR_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (reg_wr_en),
      .wr_sel   (reg_wr_sel),
      .wr_be    (reg_wr_be),
      .wr_data  (reg_wr_data),
      .done_i   (last_unit),
      .src_prog (prog_addr[0]),
      .dst_prog (prog_addr[1]),
      .cnt_load (cnt_load),
      .ctrl_q   (ctrl_q),
      .reload_o (reload)
   );

   // walker 0 follows the source, walker 1 the destination
   for (genvar g = 0; g < N_WALK; g++) begin : g_walk
      localparam int MODE_LO = (g == 0) ? CTL_SADJ : CTL_DADJ;
      mdma_addr_walk #(.ADDR_W(ADDR_W), .IS_SRC(g == 0)) u_walk (
         .clk       (clk),
         .rst_n     (rst_n),
         .load_i    (reload),
         .load_addr (prog_addr[g]),
         .step_i    (unit_done),
         .mode_i    (ctrl_q[MODE_LO +: 2]),
         .wide_i    (ctrl_q[CTL_WIDE]),
         .addr_o    (work_addr[g]),
         .err_o     (walk_err[g])
      );
   end

   mdma_unit_seq #(.ADDR_W(ADDR_W)) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .en_i        (ctrl_q[CTL_EN]),
      .wide_i      (ctrl_q[CTL_WIDE]),
      .irq_en_i    (ctrl_q[CTL_IRQ]),
      .load_i      (reload),
      .load_cnt    (cnt_load),
      .src_addr    (work_addr[0]),
      .dst_addr    (work_addr[1]),
      .mem_rdata   (mem_rdata),
      .mem_ready   (mem_ready),
      .mem_req     (mem_req),
      .mem_we      (mem_we),
      .mem_addr    (mem_addr),
      .mem_wdata   (mem_wdata),
      .unit_done_o (unit_done),
      .last_o      (last_unit),
      .irq_o       (irq)
   );

   assign ctrl_rd  = ctrl_q;
   assign mem_wide = ctrl_q[CTL_WIDE];
   assign src_err  = |walk_err;

endmodule

// File: rtl/mdma_channel_chk.sv
module mdma_channel_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic [15:0]       ctrl_rd,
   input logic              mem_req,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_ready,
   input logic              irq,
   input logic              src_err
);

   p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

   p_write_after_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we && mem_ready) |=> (mem_req && mem_we));

   p_irq_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);

   p_irq_disarmed_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (!ctrl_rd[15] && ctrl_rd[14]));

   p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      src_err |=> src_err);

   p_quiet_when_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_rd[15] && !mem_req) |=> !mem_req);

endmodule

bind mdma_channel mdma_channel_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ctrl_rd   (ctrl_rd),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .mem_addr  (mem_addr),
   .mem_ready (mem_ready),
   .irq       (irq),
   .src_err   (src_err)
);

// File: tb/mdma_channel_bench.sv
module mdma_channel_bench;

   localparam logic [31:0] SRC_MASK = 32'h07FF_FFFF;
   localparam logic [31:0] DST_MASK = 32'h07FF_FFFF;
   localparam logic [15:0] CNT_MASK = 16'h3FFF;

   typedef struct {
      bit          we;
      logic [31:0] addr;
      logic [31:0] data;
      bit          wide;
      string       tag;
   } item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr_en = 1'b0;
   logic [1:0]  reg_wr_sel = '0;
   logic [1:0]  reg_wr_be = '0;
   logic [31:0] reg_wr_data = '0;
   logic [15:0] ctrl_rd;
   logic        mem_req, mem_we, mem_wide;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic        mem_ready = 1'b0;
   logic        irq, src_err;

   item_t exp_q[$];
   int checks = 0;
   int errors = 0;
   int lat = 0;
   int wcnt = 0;
   int irq_seen = 0;

   always #5 clk = ~clk;

   mdma_channel u_mdma_channel (
      .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_sel(reg_wr_sel),
      .reg_wr_be(reg_wr_be), .reg_wr_data(reg_wr_data), .ctrl_rd(ctrl_rd),
      .mem_req(mem_req), .mem_we(mem_we), .mem_wide(mem_wide), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
      .irq(irq), .src_err(src_err)
   );

   function automatic logic [31:0] mem_fn(input logic [31:0] a);
      return {a[15:0] ^ 16'h5A5A, a[31:16] ^ a[15:0] ^ 16'h3C3C};
   endfunction

   assign mem_rdata = mem_fn(mem_addr);

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // memory model and scoreboard monitor
   always @(negedge clk) begin
      if (!rst_n) begin
         mem_ready = 1'b0;
         wcnt = 0;
      end else if (mem_req) begin
         if (wcnt >= lat) begin
            mem_ready = 1'b1;
            wcnt = 0;
            if (exp_q.size() == 0) begin
               check(1'b0, "R9", "unexpected access", mem_addr, 32'h0);
            end else begin
               item_t it;
               it = exp_q.pop_front();
               check(mem_we == it.we, it.tag, "direction", 32'(mem_we), 32'(it.we));
               check(mem_addr == it.addr, it.tag, "address", mem_addr, it.addr);
               check(mem_wide == it.wide, it.tag, "size", 32'(mem_wide), 32'(it.wide));
               if (it.we)
                  check(mem_wdata == it.data, it.tag, "write data", mem_wdata, it.data);
            end
         end else begin
            mem_ready = 1'b0;
            wcnt++;
         end
      end else begin
         mem_ready = 1'b0;
         wcnt = 0;
      end
      if (irq) irq_seen++;
   end

   task automatic reg_write(input logic [1:0] sel, input logic [1:0] be, input logic [31:0] data);
      @(negedge clk);
      reg_wr_en   = 1'b1;
      reg_wr_sel  = sel;
      reg_wr_be   = be;
      reg_wr_data = data;
      @(negedge clk);
      reg_wr_en   = 1'b0;
   endtask

   // driver: expected accesses from programmed values and control
   task automatic plan(input logic [31:0] src, input logic [31:0] dst, input logic [15:0] cnt,
                       input logic [15:0] ctl, input string tag);
      logic [31:0] s, d, step, rd;
      int n;
      bit wide;
      s = src & SRC_MASK;
      d = dst & DST_MASK;
      n = int'(cnt & CNT_MASK);
      if (n == 0) n = int'(CNT_MASK);
      wide = ctl[10];
      step = wide ? 32'd4 : 32'd2;
      for (int i = 0; i < n; i++) begin
         item_t r, w;
         rd = mem_fn(s);
         r.we = 1'b0; r.addr = s; r.data = '0; r.wide = wide; r.tag = tag;
         w.we = 1'b1; w.addr = d; w.wide = wide; w.tag = tag;
         w.data = wide ? rd : {16'h0, rd[15:0]};
         exp_q.push_back(r);
         exp_q.push_back(w);
         case (ctl[8:7])
            2'd0: s = s + step;
            2'd1: s = s - step;
            default: s = s;
         endcase
         case (ctl[6:5])
            2'd1: d = d - step;
            2'd2: d = d;
            default: d = d + step;
         endcase
      end
   endtask

   task automatic wait_idle(input string tag);
      int n = 0;
      while ((exp_q.size() != 0 || mem_req || ctrl_rd[15]) && n < 100000) begin
         @(negedge clk);
         n++;
      end
      if (n >= 100000) check(1'b0, tag, "transfer never completed", 32'(exp_q.size()), 32'h0);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      check(1'b0, "R9", "watchdog expired", 32'h1, 32'h0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int i0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R11: reset state
      check(ctrl_rd == 16'h0, "R11", "control after reset", 32'(ctrl_rd), 32'h0);
      check(!mem_req, "R11", "request after reset", 32'(mem_req), 32'h0);
      check(!irq, "R11", "irq after reset", 32'(irq), 32'h0);
      check(!src_err, "R8", "error flag after reset", 32'(src_err), 32'h0);

      // R11: control bits kept while disabled, no access issued
      reg_write(2'd2, 2'b10, {16'h0A1F, 16'hFFFF});
      repeat (10) @(negedge clk);
      check(ctrl_rd == 16'h0A1F, "R11", "control readback", 32'(ctrl_rd), 32'h0A1F);
      check(!mem_req, "R11", "no request while disabled", 32'(mem_req), 32'h0);

      // R1 R2 R6 R7 R10 R12: 32-bit, both increment, address masking, irq on
      lat = 1;
      reg_write(2'd0, 2'b00, 32'hF800_0010);
      reg_write(2'd1, 2'b00, 32'hFFFF_FF00);
      reg_write(2'd2, 2'b01, 32'h0000_0003);
      plan(32'hF800_0010, 32'hFFFF_FF00, 16'd3, 16'hC400, "R1 R2 R6 R7 R12");
      i0 = irq_seen;
      reg_write(2'd2, 2'b10, {16'hC400, 16'h0});
      wait_idle("R10");
      check(irq_seen - i0 == 1, "R10", "irq pulses", 32'(irq_seen - i0), 32'd1);
      check(ctrl_rd == 16'h4400, "R10", "enable cleared, rest kept", 32'(ctrl_rd), 32'h4400);

      // R6 R7: 16-bit, source decrement, destination hold, irq off
      lat = 2;
      reg_write(2'd0, 2'b00, 32'h0000_0100);
      reg_write(2'd1, 2'b00, 32'h0000_0200);
      reg_write(2'd2, 2'b01, 32'h0000_0002);
      plan(32'h100, 32'h200, 16'd2, 16'h80C0, "R6 R7");
      i0 = irq_seen;
      reg_write(2'd2, 2'b10, {16'h80C0, 16'h0});
      wait_idle("R10");
      check(irq_seen == i0, "R10", "no irq when disabled by bit 14", 32'(irq_seen - i0), 32'd0);

      // R8 R7: source code 3 holds and flags, destination code 3 increments
      lat = 0;
      reg_write(2'd0, 2'b00, 32'h0000_0040);
      reg_write(2'd1, 2'b00, 32'h0000_1000);
      reg_write(2'd2, 2'b01, 32'h0000_0002);
      plan(32'h40, 32'h1000, 16'd2, 16'hC5E0, "R8 R7");
      i0 = irq_seen;
      reg_write(2'd2, 2'b10, {16'hC5E0, 16'h0});
      wait_idle("R8");
      check(src_err, "R8", "error flag set", 32'(src_err), 32'h1);
      check(irq_seen - i0 == 1, "R8", "transfer completes", 32'(irq_seen - i0), 32'd1);

      // R3 R12: combined write, count truncated to 14 bits (0xC002 -> 2)
      reg_write(2'd0, 2'b00, 32'h0000_2000);
      reg_write(2'd1, 2'b00, 32'h0000_3000);
      plan(32'h2000, 32'h3000, 16'hC002, 16'hC400, "R3 R12");
      reg_write(2'd2, 2'b11, {16'hC400, 16'hC002});
      wait_idle("R3");
      check(src_err, "R8", "error flag still set", 32'(src_err), 32'h1);

      // R4: writes during a transfer do not disturb it
      lat = 3;
      reg_write(2'd0, 2'b00, 32'h0000_0500);
      reg_write(2'd1, 2'b00, 32'h0000_0600);
      reg_write(2'd2, 2'b01, 32'h0000_0004);
      plan(32'h500, 32'h600, 16'd4, 16'hC400, "R4");
      i0 = irq_seen;
      reg_write(2'd2, 2'b10, {16'hC400, 16'h0});
      repeat (4) @(negedge clk);
      reg_write(2'd0, 2'b00, 32'h0000_7000);
      reg_write(2'd2, 2'b10, {16'hC400, 16'h0});
      reg_write(2'd2, 2'b01, 32'h0000_0009);
      wait_idle("R4");
      check(irq_seen - i0 == 1, "R4", "single completion", 32'(irq_seen - i0), 32'd1);

      // R4: next arming uses the values written meanwhile
      lat = 0;
      plan(32'h7000, 32'h600, 16'd9, 16'h8000, "R4");
      reg_write(2'd2, 2'b10, {16'h8000, 16'h0});
      wait_idle("R4");

      // R5: zero count gives 16383 units
      reg_write(2'd0, 2'b00, 32'h0000_0000);
      reg_write(2'd1, 2'b00, 32'h0400_0000);
      reg_write(2'd2, 2'b01, 32'h0000_0000);
      plan(32'h0, 32'h0400_0000, 16'd0, 16'hC040, "R5");
      i0 = irq_seen;
      reg_write(2'd2, 2'b10, {16'hC040, 16'h0});
      wait_idle("R5");
      check(irq_seen - i0 == 1, "R5", "completion after full count", 32'(irq_seen - i0), 32'd1);
      check(exp_q.size() == 0, "R5", "all units seen", 32'(exp_q.size()), 32'h0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule